// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a management-bus master for reaching the registers of an external Ethernet PHY. Software packs a whole request into one 32-bit command word: the 16-bit data, the 5-bit PHY register number, the 5-bit PHY address, a 2-bit opcode and an interrupt-enable flag. A valid opcode starts a single management frame on MDC/MDIO. When the frame ends, the block sets the ready flag. On a read, it puts the 16 returned bits into the data field and sets the error flag if no PHY answered. The block can also raise a completion interrupt cause.

MDC is made from the system clock by a divider with a half-period of `DIV_HALF` clock cycles, and it runs only while a frame is in progress. A state machine walks through the frame. Its states are IDLE, PREAMBLE, HEADER, TURN and DATA. IDLE goes to PREAMBLE when a command is accepted. PREAMBLE goes to HEADER after bit 31, HEADER goes to TURN after bit 45, and TURN goes to DATA after bit 47. DATA goes back to IDLE after bit 63, and that step is the completion. Every transition happens on an MDC falling edge.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the command word reads 0x1000_0000 (only ready, bit 28, set), MDC is low, and both the interrupt and the MDIO output enable are low.
- R2: Command word fields are: data [15:0], register [20:16], PHY address [25:21], opcode [27:26], ready [28], interrupt enable [29], error [30], and bit 31 reads zero. A write with opcode 01 (write) or 10 (read) loads the fields, clears ready and error, and starts a frame. A write with opcode 00 or 11 changes nothing and starts nothing.
- R3: A command write that arrives while ready is 0 is ignored, and the fields stay as the accepted command set them.
- R4: At each MDC rising edge the bits on MDIO are, MSB first: 32 ones, start 01, opcode, PHY address, register address, then on a write the turnaround 10 and the 16 data bits.
- R5: On a read, the output enable is high for the first 46 bits and low for the turnaround and data. The 16 bits sampled at MDC rising edges during the data phase replace the data field.
- R6: The error bit is set at the end of a read if MDIO is high at the rising edge of the second turnaround bit. A write never sets it.
- R7: Ready returns to 1 exactly 128*DIV_HALF clock cycles after the accepting edge. MDC is low whenever ready is 1.
- R8: At completion the interrupt output becomes the command's interrupt-enable bit. The interrupt is cleared when the next command is accepted.
- R9: MDC is high for DIV_HALF cycles in each of its 64 periods per frame, and MDIO changes only together with an MDC falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word written |
| cmd_rdata | output | 32 | Current command/status word |
| mdio_irq | output | 1 | Management-access-complete interrupt cause |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pin |

## Verification
The assertions assume that mdio_i reflects the line, and that the line is pulled high whenever no one drives it. The stimulus meets this in two ways. It loops mdio_o back whenever the output enable is high. When the enable is low, a bench PHY model drives the line from a count of MDC falling edges, or leaves it high to stand for a missing PHY. The assertions also assume that command writes come as single-cycle strobes on the port, which the bench tasks always produce.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;

    localparam int FRAME_BITS = 64;
    localparam int LAST_HDR   = 45;
    localparam int LAST_TA    = 47;
    localparam int LAST_PRE   = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA
    } mdio_state_t;
endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = $clog2(DIV_HALF + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap      = run && (cnt_q == CNT_TOP);
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [1:0]  op,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wdata,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rd_data,
    output logic        ta_fail
);
    localparam logic [5:0] IDX_PRE  = 6'(LAST_PRE);
    localparam logic [5:0] IDX_HDR  = 6'(LAST_HDR);
    localparam logic [5:0] IDX_TA   = 6'(LAST_TA);
    localparam logic [5:0] IDX_LAST = 6'(FRAME_BITS - 1);

    mdio_state_t state_q, state_d;
    logic [5:0]  bit_idx;
    logic [31:0] sr_q;
    logic        is_read;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic: every step beyond IDLE happens on an MDC fall
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (fall_tick && bit_idx == IDX_PRE)  state_d = ST_HEADER;
            ST_HEADER:   if (fall_tick && bit_idx == IDX_HDR)  state_d = ST_TURN;
            ST_TURN:     if (fall_tick && bit_idx == IDX_TA)   state_d = ST_DATA;
            ST_DATA:     if (fall_tick && bit_idx == IDX_LAST) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // frame datapath: bit counter, transmit shifter, receive capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx <= '0;
            sr_q    <= '0;
            is_read <= 1'b0;
            rd_data <= '0;
            ta_fail <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            if (start) begin
                bit_idx <= '0;
                sr_q    <= {2'b01, op, phy_addr, reg_addr, 2'b10, wdata};
                is_read <= (op == OP_READ);
                ta_fail <= 1'b0;
            end
        end else begin
            if (rise_tick) begin
                if (state_q == ST_TURN && bit_idx == IDX_TA && is_read)
                    ta_fail <= mdio_i;
                if (state_q == ST_DATA)
                    rd_data <= {rd_data[14:0], mdio_i};
            end
            if (fall_tick) begin
                bit_idx <= bit_idx + 1'b1;
                if (state_q != ST_PREAMBLE)
                    sr_q <= {sr_q[30:0], 1'b0};
            end
        end
    end

    // outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_DATA) && fall_tick && (bit_idx == IDX_LAST);
        mdio_o  = (state_q == ST_IDLE || state_q == ST_PREAMBLE) ? 1'b1 : sr_q[31];
        mdio_oe = busy && !(is_read && (state_q == ST_TURN || state_q == ST_DATA));
    end
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_rdata,
    output logic        mdio_irq,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [15:0] data_q;
    logic [4:0]  reg_q;
    logic [4:0]  phy_q;
    logic [1:0]  op_q;
    logic        ready_q, ie_q, err_q;

    logic        busy, done, ta_fail, rise_tick, fall_tick, accept;
    logic [15:0] rd_data;
    logic [1:0]  wr_op;

    assign wr_op  = cmd_wdata[27:26];
    assign accept = cmd_wr && !busy && (wr_op == OP_WRITE || wr_op == OP_READ);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= '0;
            reg_q    <= '0;
            phy_q    <= '0;
            op_q     <= '0;
            ready_q  <= 1'b1;
            ie_q     <= 1'b0;
            err_q    <= 1'b0;
            mdio_irq <= 1'b0;
        end else if (accept) begin
            data_q   <= cmd_wdata[15:0];
            reg_q    <= cmd_wdata[20:16];
            phy_q    <= cmd_wdata[25:21];
            op_q     <= wr_op;
            ie_q     <= cmd_wdata[29];
            ready_q  <= 1'b0;
            err_q    <= 1'b0;
            mdio_irq <= 1'b0;
        end else if (done) begin
            ready_q  <= 1'b1;
            mdio_irq <= ie_q;
            if (op_q == OP_READ) begin
                data_q <= rd_data;
                err_q  <= ta_fail;
            end
        end
    end

    assign cmd_rdata = {1'b0, err_q, ie_q, ready_q, op_q, phy_q, reg_q, data_q};

    mdio_mdc_div #(.DIV_HALF(DIV_HALF)) div_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .op        (wr_op),
        .phy_addr  (cmd_wdata[25:21]),
        .reg_addr  (cmd_wdata[20:16]),
        .wdata     (cmd_wdata[15:0]),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .done      (done),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rd_data   (rd_data),
        .ta_fail   (ta_fail)
    );
endmodule

// File: rtl/mdio_cmd_chk.sv
module mdio_cmd_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] cmd_rdata,
    input logic        mdio_irq,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    // R7: MDC idles low whenever the controller is ready
    a_r7_mdc_low_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rdata[28] |-> !mdc);

    // R8: the interrupt only ever follows an enabled command
    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_irq |-> cmd_rdata[29]);

    // R6: a write command never leaves the error flag set
    a_r6_write_no_error: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rdata[27:26] == 2'b01) |-> !cmd_rdata[30]);

    // R9: MDIO moves only with an MDC falling edge
    a_r9_mdio_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> $fell(mdc));

    // R3: fields hold while busy, until completion
    a_r3_busy_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_rdata[28] |=> (cmd_rdata[28] || $stable(cmd_rdata[27:0])));

    // R4: a write frame keeps the line driven throughout
    a_r4_write_drives_line: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_rdata[28] && cmd_rdata[27:26] == 2'b01) |-> mdio_oe);

    // R2: reserved top bit always reads zero
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_rdata[31]);
endmodule

bind mdio_cmd_ctrl mdio_cmd_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_rdata (cmd_rdata),
    .mdio_irq  (mdio_irq),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/mdio_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_cmd_ctrl_tb_top;
    localparam int DIV_HALF = 2;
    localparam int TXN_CYC  = 128 * DIV_HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        mdio_irq, mdc, mdio_o, mdio_oe, mdio_i;

    int n_tests = 0;
    int n_fail  = 0;

    // PHY model state
    int          fall_cnt = 0;
    int          base_fall = 0;
    logic        phy_on = 1'b1;
    logic [15:0] reply = '0;
    logic        phy_line;
    logic [63:0] cap = '0;
    int          rise_cnt = 0;
    int          rise_oe_cnt = 0;
    int          hi_cnt = 0;

    always #4 clk = ~clk;

    mdio_cmd_ctrl #(.DIV_HALF(DIV_HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .mdio_irq(mdio_irq), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always @(negedge mdc) fall_cnt <= fall_cnt + 1;
    always @(posedge mdc) begin
        rise_cnt <= rise_cnt + 1;
        if (mdio_oe) begin
            rise_oe_cnt <= rise_oe_cnt + 1;
            cap <= {cap[62:0], mdio_o};
        end
    end
    always @(posedge clk) if (mdc) hi_cnt <= hi_cnt + 1;

    always_comb begin
        int idx;
        idx = fall_cnt - base_fall;
        if (!phy_on)                   phy_line = 1'b1;
        else if (idx == 47)            phy_line = 1'b0;
        else if (idx >= 48 && idx <= 63) phy_line = reply[63 - idx];
        else                           phy_line = 1'b1;
    end
    assign mdio_i = mdio_oe ? mdio_o : phy_line;

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input logic [1:0] op, input logic [4:0] phy,
                                         input logic [4:0] rg, input logic [15:0] d,
                                         input logic ie);
        return {1'b0, 1'b0, ie, 1'b0, op, phy, rg, d};
    endfunction

    // issue one command and wait for ready; returns cycles from accept edge
    task automatic run_cmd(input logic [31:0] w, output int cyc);
        @(negedge clk);
        base_fall = fall_cnt;
        cmd_wdata = w;
        cmd_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_wr = 1'b0;
        cyc = 0;
        while (!cmd_rdata[28] && cyc < 5000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int cyc, r0, ro0, h0;
        logic [31:0] w, prev;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 word", cmd_rdata, 32'h1000_0000);
        chk("R1 mdc/irq/oe", {mdc, mdio_irq, mdio_oe}, 3'b000);

        // R2 invalid opcodes ignored
        prev = cmd_rdata;
        r0 = rise_cnt;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            cmd_wdata = {2'b01, (k == 0) ? 2'b00 : 2'b11, 28'h0ABC_DEF} | 32'h2000_0000;
            cmd_wdata[27:26] = (k == 0) ? 2'b00 : 2'b11;
            cmd_wr = 1'b1;
            @(negedge clk);
            cmd_wr = 1'b0;
            repeat (20) @(negedge clk);
            chk("R2 bad opcode word unchanged", cmd_rdata, prev);
            chk("R2 bad opcode no MDC", rise_cnt - r0, 0);
        end

        // write sweep: R2 R4 R6 R7 R8 R9
        for (int i = 0; i < 6; i++) begin
            logic [4:0] phy, rg;
            logic [15:0] d;
            logic ie;
            phy = 5'(i * 7 + 1);
            rg  = 5'(31 - i * 5);
            d   = 16'(16'hA5C3 ^ (i * 16'h1111));
            ie  = i[0];
            w = word(2'b01, phy, rg, d, ie);
            r0 = rise_cnt; ro0 = rise_oe_cnt; h0 = hi_cnt;
            run_cmd(w, cyc);
            chk("R7 write cycles", cyc, TXN_CYC);
            chk("R4 write frame", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, d});
            chk("R2 write word", cmd_rdata, w | 32'h1000_0000);
            chk("R6 write no error", cmd_rdata[30], 1'b0);
            chk("R8 irq follows enable", mdio_irq, ie);
            chk("R9 mdc periods", rise_cnt - r0, 64);
            chk("R9 mdc high time", hi_cnt - h0, 64 * DIV_HALF);
            chk("R7 mdc low at end", mdc, 1'b0);
            chk("R4 write oe bits", rise_oe_cnt - ro0, 64);
        end

        // read sweep: R5 R6 R8
        phy_on = 1'b1;
        for (int i = 0; i < 6; i++) begin
            logic [4:0] phy, rg;
            phy = 5'(i * 3 + 2);
            rg  = 5'(i * 6);
            reply = 16'(16'h8001 + i * 16'h3579);
            w = word(2'b10, phy, rg, 16'h5555, 1'b1);
            ro0 = rise_oe_cnt;
            run_cmd(w, cyc);
            chk("R7 read cycles", cyc, TXN_CYC);
            chk("R4 read header", cap[45:0], {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg});
            chk("R5 read oe bits", rise_oe_cnt - ro0, 46);
            chk("R5 read data", cmd_rdata[15:0], reply);
            chk("R6 read ok no error", cmd_rdata[30], 1'b0);
            chk("R8 irq on read", mdio_irq, 1'b1);
        end

        // R6 absent PHY
        phy_on = 1'b0;
        run_cmd(word(2'b10, 5'd9, 5'd3, 16'h0000, 1'b0), cyc);
        chk("R6 no PHY error", cmd_rdata[30], 1'b1);
        chk("R5 no PHY data", cmd_rdata[15:0], 16'hFFFF);
        chk("R8 irq off", mdio_irq, 1'b0);
        phy_on = 1'b1;

        // R8 irq cleared on next accept
        run_cmd(word(2'b01, 5'd1, 5'd2, 16'h1234, 1'b1), cyc);
        chk("R8 irq set", mdio_irq, 1'b1);
        @(negedge clk);
        base_fall = fall_cnt;
        w = word(2'b01, 5'd4, 5'd5, 16'hBEEF, 1'b0);
        cmd_wdata = w;
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk("R8 irq cleared on accept", mdio_irq, 1'b0);
        chk("R2 ready cleared on accept", cmd_rdata[28], 1'b0);

        // R3 write while busy ignored
        repeat (30) @(negedge clk);
        cmd_wdata = word(2'b10, 5'd30, 5'd29, 16'h0F0F, 1'b1);
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        cyc = 0;
        while (!cmd_rdata[28] && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk("R3 busy write ignored word", cmd_rdata, w | 32'h1000_0000);
        chk("R3 busy write frame", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd4, 5'd5, 2'b10, 16'hBEEF});
        chk("R3 busy write no irq", mdio_irq, 1'b0);

        finish_run();
    end
endmodule